// File: doc/BRIEF.md
# Serial Flash Suspend/Resume Controller

This block sits between the command decoder of a serial NOR flash and its internal erase/program engine. Each cycle it may receive one decoded opcode. It starts the engine on an erase or program opcode, and it decides whether a suspend request (75h) or a resume request (7Ah) is honoured. It drives the BUSY and SUS status bits. While an operation is paused, it filters which later opcodes may go on to the decoder.

The engine is modelled as a countdown of `OP_LEN` run cycles. The countdown freezes while paused and continues from the same point after a resume. A pause is a handshake: the sequencer raises a pause request, and the engine acknowledges after `ACK_LAT` cycles. BUSY falls only when that acknowledge arrives. The suspend budget `TSUS`, in clock cycles, must satisfy `ACK_LAT + 1 <= TSUS`. The same budget sets the lockout after a resume, during which a new suspend is not honoured.

Suspend and resume opcodes are consumed by this block. They never reach the decoder and never raise a reject. While an operation is paused, a new erase or program opcode that passes the filter is handed to the decoder only; the engine does not start it.

Top module: `sfl_susp_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no command, `busy`, `sus`, `fwd_valid` and `cmd_reject` are all 0.
- R2: With `busy` and `sus` both 0, an operation opcode (erase: 20h, 52h, D8h, C7h, 60h, 44h; program: 02h, 32h, 42h) is forwarded one cycle after it is presented. `busy` rises in that same cycle and stays high for exactly `OP_LEN` cycles. A non-operation opcode such as 03h is forwarded and leaves `busy` at 0.
- R3: A 75h presented while a sector/block erase (20h, 52h, D8h) or a page/quad-page program (02h, 32h) is running is honoured. `sus` is 1 in the next cycle, and `busy` falls exactly `ACK_LAT + 1` cycles after the suspend was sampled, which is within `TSUS`.
- R4: A 75h is ignored when no operation runs, and also during a chip erase (C7h, 60h) or the non-suspendable operations 44h and 42h. In those cases `sus` stays 0 and the operation still ends after `OP_LEN` busy cycles.
- R5: A 75h presented while `sus` is 1 changes nothing: `sus` stays 1 and `busy` stays 0.
- R6: While an erase is suspended, 01h and every erase opcode (20h, 52h, D8h, C7h, 60h, 44h) are dropped. Each one gives a one-cycle `cmd_reject` pulse in the following cycle and is not forwarded.
- R7: While a program is suspended, 01h and every program opcode (02h, 32h, 42h) are dropped in the same way, with a one-cycle `cmd_reject` pulse.
- R8: While suspended, every other opcode except 75h and 7Ah is forwarded unchanged one cycle later, with no reject.
- R9: A 7Ah presented while `sus` is 1 and `busy` is 0 clears `sus` and sets `busy` in the next cycle. The operation then stays busy for the run cycles it had left: `OP_LEN` minus the run cycles before the suspend. A 7Ah presented while `sus` is 0 is ignored.
- R10: A 75h presented fewer than `TSUS` cycles after an accepted 7Ah is ignored. One presented exactly `TSUS` cycles after it is honoured.
- R11: `pwr_lost` ends any operation or suspend. In the next cycle `sus` and `busy` are both 0.
- R12: 75h and 7Ah are never forwarded and never raise `cmd_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_lost | input | 1 | Power-loss event; clears all operation and suspend state |
| cmd_valid | input | 1 | A decoded opcode is present this cycle |
| cmd_op | input | 8 | Decoded opcode |
| fwd_valid | output | 1 | Opcode released to the decoder |
| fwd_op | output | 8 | Released opcode |
| cmd_reject | output | 1 | One-cycle pulse: opcode dropped because it is forbidden while suspended |
| busy | output | 1 | BUSY status bit |
| sus | output | 1 | SUS status bit |

## Verification
Every output is registered, so `fwd_valid`, `fwd_op`, `cmd_reject` and `sus` react in the cycle after the edge that samples the opcode. `busy` rises in that same cycle. It falls `ACK_LAT + 1` cycles after an accepted suspend, and `OP_LEN` run cycles after a start or the remaining count after a resume. The bench drives inputs on the falling edge and samples one falling edge after the sampling rising edge. It counts busy cycles edge by edge, so that each expected count is exact and not a window. The opcode filter is swept over all 254 non-control opcodes for both suspend kinds. The lockout is swept over every gap from 1 to `TSUS + 1` cycles.

// File: rtl/sfl_susp_pkg.sv
// Shared opcodes, operation classes and sequencer states for the
// suspend/resume controller. Assumes 8-bit decoded opcodes.
package sfl_susp_pkg;

    localparam logic [7:0] OPC_SUSPEND = 8'h75;
    localparam logic [7:0] OPC_RESUME  = 8'h7A;
    localparam logic [7:0] OPC_WRSTAT  = 8'h01;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_SECT_ERASE,
        OPK_CHIP_ERASE,
        OPK_AUX_ERASE,
        OPK_PAGE_PROG,
        OPK_AUX_PROG
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_HELD
    } seq_state_e;

    // True for any opcode that erases array content.
    function automatic logic op_is_erase(input logic [7:0] op);
        return op inside {8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44};
    endfunction

    // True for any opcode that programs array content.
    function automatic logic op_is_prog(input logic [7:0] op);
        return op inside {8'h02, 8'h32, 8'h42};
    endfunction

    // Maps an opcode to the class of engine operation it starts.
    function automatic op_kind_e op_classify(input logic [7:0] op);
        case (op)
            8'h20, 8'h52, 8'hD8: return OPK_SECT_ERASE;
            8'hC7, 8'h60:        return OPK_CHIP_ERASE;
            8'h44:               return OPK_AUX_ERASE;
            8'h02, 8'h32:        return OPK_PAGE_PROG;
            8'h42:               return OPK_AUX_PROG;
            default:             return OPK_NONE;
        endcase
    endfunction

    // Only sector/block erase and page/quad-page program may be paused.
    function automatic logic op_can_suspend(input op_kind_e k);
        return (k == OPK_SECT_ERASE) || (k == OPK_PAGE_PROG);
    endfunction

endpackage

// File: rtl/sfl_cmd_gate.sv
// Command gate: releases decoded opcodes to the decoder or drops them.
// While suspended, it applies the opcode filter picked by the latched
// suspend kind. Suspend/resume opcodes are always consumed here.
// Assumes sus and susp_erase are registered status from the sequencer.
module sfl_cmd_gate
    import sfl_susp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_lost,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       sus,
    input  logic       susp_erase,
    output logic       fwd_valid,
    output logic [7:0] fwd_op,
    output logic       reject
);

    logic is_ctl;
    logic blocked;

    // Classify the incoming opcode against the active filter.
    always_comb begin
        is_ctl  = (cmd_op == OPC_SUSPEND) || (cmd_op == OPC_RESUME);
        blocked = sus && ((cmd_op == OPC_WRSTAT) ||
                          (susp_erase ? op_is_erase(cmd_op) : op_is_prog(cmd_op)));
    end

    // Register the forward/reject decision for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_lost) begin
            fwd_valid <= 1'b0;
            fwd_op    <= '0;
            reject    <= 1'b0;
        end else begin
            fwd_valid <= cmd_valid && !is_ctl && !blocked;
            reject    <= cmd_valid && !is_ctl && blocked;
            if (cmd_valid) begin
                fwd_op <= cmd_op;
            end
        end
    end

endmodule

// File: rtl/sfl_op_engine.sv
// Model of the erase/program engine: a run countdown that freezes while
// paused, plus a pause acknowledge that follows ACK_LAT cycles after the
// request. Assumes ACK_LAT >= 1 and OP_LEN >= 2.
module sfl_op_engine
    import sfl_susp_pkg::*;
#(
    parameter int OP_LEN  = 40,
    parameter int ACK_LAT = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_lost,
    input  logic     start,
    input  op_kind_e start_kind,
    input  logic     run_en,
    input  logic     pause_req,
    output logic     eng_last,
    output op_kind_e eng_kind,
    output logic     eng_paused
);

    localparam int REM_W = $clog2(OP_LEN + 1);

    logic [REM_W-1:0] rem;

    // Load, count down and clear the operation progress.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_lost) begin
            rem      <= '0;
            eng_kind <= OPK_NONE;
        end else if (start) begin
            rem      <= REM_W'(OP_LEN);
            eng_kind <= start_kind;
        end else if (run_en && rem != '0) begin
            rem <= rem - REM_W'(1);
            if (rem == REM_W'(1)) begin
                eng_kind <= OPK_NONE;
            end
        end
    end

    // Final run cycle of the current operation.
    always_comb begin
        eng_last = run_en && (rem == REM_W'(1));
    end

    generate
        if (ACK_LAT <= 1) begin : g_ack_direct
            // Acknowledge one cycle after the pause request.
            always_ff @(posedge clk) begin
                if (!rst_n || pwr_lost) begin
                    eng_paused <= 1'b0;
                end else begin
                    eng_paused <= pause_req;
                end
            end
        end else begin : g_ack_count
            localparam int AW = $clog2(ACK_LAT);
            logic [AW-1:0] ack_cnt;
            // Count ACK_LAT cycles of pause request, then acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n || pwr_lost || !pause_req) begin
                    ack_cnt    <= '0;
                    eng_paused <= 1'b0;
                end else if (!eng_paused) begin
                    if (ack_cnt == AW'(ACK_LAT - 1)) begin
                        eng_paused <= 1'b1;
                    end else begin
                        ack_cnt <= ack_cnt + AW'(1);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sfl_susp_seq.sv
// Suspend sequencer: owns BUSY/SUS and decides when operations start and
// when suspend or resume is honoured. Latches the kind of the interrupted
// operation and runs the lockout after a resume.
// Assumes eng_kind/eng_last come from the engine of the same cycle.
module sfl_susp_seq
    import sfl_susp_pkg::*;
#(
    parameter int TSUS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_lost,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       eng_last,
    input  op_kind_e   eng_kind,
    input  logic       eng_paused,
    output logic       start,
    output op_kind_e   start_kind,
    output logic       run_en,
    output logic       pause_req,
    output logic       busy,
    output logic       sus,
    output logic       susp_erase
);

    localparam int LOCK_W = (TSUS > 1) ? $clog2(TSUS) : 1;

    seq_state_e       state, state_nx;
    logic [LOCK_W-1:0] lock_cnt;
    logic             susp_ok;
    logic             resume_ok;

    // Qualify start, suspend and resume for this cycle.
    always_comb begin
        start_kind = op_classify(cmd_op);
        start      = cmd_valid && !pwr_lost && (state == ST_IDLE) &&
                     (start_kind != OPK_NONE);
        susp_ok    = cmd_valid && (cmd_op == OPC_SUSPEND) && (state == ST_RUN) &&
                     !eng_last && (lock_cnt == '0) && op_can_suspend(eng_kind);
        resume_ok  = cmd_valid && (cmd_op == OPC_RESUME) && (state == ST_HELD);
    end

    // Next-state selection; power loss overrides everything.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start) state_nx = ST_RUN;
            ST_RUN:   if (eng_last) state_nx = ST_IDLE;
                      else if (susp_ok) state_nx = ST_PAUSE;
            ST_PAUSE: if (eng_paused) state_nx = ST_HELD;
            ST_HELD:  if (resume_ok) state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
        if (pwr_lost) begin
            state_nx = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Latch whether the interrupted operation was an erase.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_lost) begin
            susp_erase <= 1'b0;
        end else if (susp_ok && !eng_last) begin
            susp_erase <= (eng_kind == OPK_SECT_ERASE);
        end
    end

    // Lockout countdown started by an accepted resume.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_lost) begin
            lock_cnt <= '0;
        end else if (resume_ok) begin
            lock_cnt <= LOCK_W'(TSUS - 1);
        end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - LOCK_W'(1);
        end
    end

    // Status and engine controls decoded from the state.
    always_comb begin
        run_en    = (state == ST_RUN);
        pause_req = (state == ST_PAUSE) || (state == ST_HELD);
        busy      = (state == ST_RUN) || (state == ST_PAUSE);
        sus       = (state == ST_PAUSE) || (state == ST_HELD);
    end

endmodule

// File: rtl/sfl_susp_ctrl.sv
// Top of the suspend/resume controller: joins the sequencer, the
// command gate and the engine model. Requires ACK_LAT + 1 <= TSUS.
module sfl_susp_ctrl
    import sfl_susp_pkg::*;
#(
    parameter int TSUS    = 8,
    parameter int ACK_LAT = 3,
    parameter int OP_LEN  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_lost,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    output logic       fwd_valid,
    output logic [7:0] fwd_op,
    output logic       cmd_reject,
    output logic       busy,
    output logic       sus
);

    logic     start;
    op_kind_e start_kind;
    logic     run_en;
    logic     pause_req;
    logic     susp_erase;
    logic     eng_last;
    op_kind_e eng_kind;
    logic     eng_paused;

    sfl_susp_seq #(
        .TSUS(TSUS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_lost   (pwr_lost),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .eng_last   (eng_last),
        .eng_kind   (eng_kind),
        .eng_paused (eng_paused),
        .start      (start),
        .start_kind (start_kind),
        .run_en     (run_en),
        .pause_req  (pause_req),
        .busy       (busy),
        .sus        (sus),
        .susp_erase (susp_erase)
    );

    sfl_cmd_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_lost   (pwr_lost),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .sus        (sus),
        .susp_erase (susp_erase),
        .fwd_valid  (fwd_valid),
        .fwd_op     (fwd_op),
        .reject     (cmd_reject)
    );

    sfl_op_engine #(
        .OP_LEN  (OP_LEN),
        .ACK_LAT (ACK_LAT)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_lost   (pwr_lost),
        .start      (start),
        .start_kind (start_kind),
        .run_en     (run_en),
        .pause_req  (pause_req),
        .eng_last   (eng_last),
        .eng_kind   (eng_kind),
        .eng_paused (eng_paused)
    );

endmodule

// File: rtl/sfl_susp_ctrl_chk.sv
// Port-level protocol checker for the suspend/resume controller,
// attached to every instance of the top by the bind below.
module sfl_susp_ctrl_chk #(
    parameter int TSUS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_lost,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       fwd_valid,
    input logic [7:0] fwd_op,
    input logic       cmd_reject,
    input logic       busy,
    input logic       sus
);

    int unsigned pw_cnt;

    // Length of the current stretch with BUSY and SUS both high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_cnt <= 0;
        end else if (busy && sus) begin
            pw_cnt <= pw_cnt + 1;
        end else begin
            pw_cnt <= 0;
        end
    end

    // R11
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_lost |=> (!sus && !busy));

    // R12
    ctl_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ((fwd_op != 8'h75) && (fwd_op != 8'h7A)));

    // R6
    rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!fwd_valid && $past(sus)));

    // R3
    pause_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sus) |-> (pw_cnt < TSUS));

    // R9
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sus && !busy && cmd_valid && cmd_op == 8'h7A && !pwr_lost) |=> (busy && !sus));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sus && !busy && cmd_valid && cmd_op == 8'h75 && !pwr_lost) |=> (sus && !busy));

endmodule

bind sfl_susp_ctrl sfl_susp_ctrl_chk #(
    .TSUS(TSUS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_lost   (pwr_lost),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .fwd_valid  (fwd_valid),
    .fwd_op     (fwd_op),
    .cmd_reject (cmd_reject),
    .busy       (busy),
    .sus        (sus)
);

// File: tb/sfl_susp_ctrl_tb.sv
module sfl_susp_ctrl_tb;

    localparam int CLK_NS  = 10;
    localparam int TSUS    = 8;
    localparam int ACK_LAT = 3;
    localparam int OP_LEN  = 40;
    localparam int WD_MAX  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_lost = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic       fwd_valid;
    logic [7:0] fwd_op;
    logic       cmd_reject;
    logic       busy;
    logic       sus;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    sfl_susp_ctrl #(
        .TSUS(TSUS), .ACK_LAT(ACK_LAT), .OP_LEN(OP_LEN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .fwd_valid(fwd_valid), .fwd_op(fwd_op), .cmd_reject(cmd_reject),
        .busy(busy), .sus(sus)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic bit tb_erase(input int op);
        return op == 'h20 || op == 'h52 || op == 'hD8 || op == 'hC7 || op == 'h60 || op == 'h44;
    endfunction

    function automatic bit tb_prog(input int op);
        return op == 'h02 || op == 'h32 || op == 'h42;
    endfunction

    task automatic ck(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_MAX && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_MAX);
            report();
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic power_off();
        pwr_lost = 1'b1;
        @(negedge clk);
        pwr_lost = 1'b0;
    endtask

    // Counts busy cycles from the current sample point onward.
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 4 * OP_LEN) begin
            n++;
            tick();
        end
    endtask

    initial begin
        int n;
        int tot;
        logic [7:0] lst_sus[5] = '{8'h20, 8'h52, 8'hD8, 8'h02, 8'h32};
        logic [7:0] lst_non[4] = '{8'hC7, 8'h60, 8'h44, 8'h42};
        logic [7:0] lst_all[9] = '{8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44, 8'h02, 8'h32, 8'h42};

        // R1: reset state
        repeat (3) tick();
        ck("R1 busy", busy, 0);
        ck("R1 sus", sus, 0);
        ck("R1 fwd_valid", fwd_valid, 0);
        ck("R1 reject", cmd_reject, 0);
        rst_n = 1'b1;
        repeat (2) tick();
        ck("R1 busy after release", busy, 0);
        ck("R1 sus after release", sus, 0);

        // R2: every operation opcode starts a run of OP_LEN busy cycles
        foreach (lst_all[i]) begin
            send(lst_all[i]);
            ck("R2 forwarded", fwd_valid, 1);
            ck("R2 fwd_op", fwd_op, lst_all[i]);
            count_busy(n);
            ck("R2 busy length", n, OP_LEN);
            tick();
        end
        send(8'h03);
        ck("R2 read forwarded", fwd_valid, 1);
        ck("R2 read no busy", busy, 0);

        // R4, R12: suspend and resume while idle
        send(8'h75);
        ck("R4 idle suspend sus", sus, 0);
        ck("R12 suspend not forwarded", fwd_valid, 0);
        ck("R12 suspend no reject", cmd_reject, 0);
        send(8'h7A);
        ck("R9 idle resume sus", sus, 0);
        ck("R9 idle resume busy", busy, 0);
        ck("R12 resume not forwarded", fwd_valid, 0);

        // R3, R9: suspend timing and continuation for suspendable kinds
        foreach (lst_sus[i]) begin
            for (int d = 0; d <= 5; d += 5) begin
                send(lst_sus[i]);
                repeat (d) tick();
                send(8'h75);
                ck("R3 sus set", sus, 1);
                ck("R3 busy still high", busy, 1);
                ck("R12 no reject on suspend", cmd_reject, 0);
                repeat (ACK_LAT) tick();
                ck("R3 busy before ack", busy, 1);
                tick();
                ck("R3 busy dropped", busy, 0);
                send(8'h7A);
                ck("R9 sus cleared", sus, 0);
                ck("R9 busy set", busy, 1);
                count_busy(n);
                ck("R9 remaining run", n, OP_LEN - d - 1);
                repeat (TSUS) tick();
            end
        end

        // R4: non-suspendable operations ignore the suspend
        foreach (lst_non[i]) begin
            send(lst_non[i]);
            tot = 1;
            repeat (3) begin
                tick();
                tot += busy;
            end
            send(8'h75);
            ck("R4 sus stays 0", sus, 0);
            tot += busy;
            tick();
            count_busy(n);
            ck("R4 full length", tot + n, OP_LEN);
            tick();
        end

        // R5-R8: opcode filter sweep for erase and program suspend
        for (int k = 0; k < 2; k++) begin
            send(k == 0 ? 8'h20 : 8'h02);
            repeat (2) tick();
            send(8'h75);
            repeat (ACK_LAT + 1) tick();
            ck("R3 held", sus && !busy, 1);
            send(8'h75);
            ck("R5 sus kept", sus, 1);
            ck("R5 busy kept", busy, 0);
            ck("R12 no fwd", fwd_valid, 0);
            for (int op = 0; op < 256; op++) begin
                bit exp_rej;
                if (op == 'h75 || op == 'h7A) continue;
                exp_rej = (op == 'h01) || (k == 0 ? tb_erase(op) : tb_prog(op));
                send(8'(op));
                if (k == 0) ck("R6 erase-suspend reject", cmd_reject, exp_rej);
                else ck("R7 program-suspend reject", cmd_reject, exp_rej);
                ck("R8 forward", fwd_valid, !exp_rej);
                if (!exp_rej) ck("R8 fwd_op", fwd_op, op);
                if (sus != 1'b1 || busy != 1'b0) ck("R8 state kept", {sus, busy}, 2);
            end
            tick();
            ck("R6 reject one cycle", cmd_reject, 0);
            send(8'h7A);
            count_busy(n);
            ck("R9 remaining after sweep", n, OP_LEN - 3);
            repeat (TSUS) tick();
        end

        // R10, R11: lockout after resume, then power loss
        for (int j = 1; j <= TSUS + 1; j++) begin
            send(8'h20);
            send(8'h75);
            repeat (ACK_LAT + 1) tick();
            send(8'h7A);
            repeat (j - 1) tick();
            send(8'h75);
            ck("R10 lockout", sus, (j >= TSUS) ? 1 : 0);
            power_off();
            ck("R11 sus cleared", sus, 0);
            ck("R11 busy cleared", busy, 0);
            tick();
        end

        report();
    end

endmodule